// File: doc/BRIEF.md
# Audio Interrupt Pending and Channel-Loop Aggregator

This block collects the interrupt requests of an audio engine and turns them into one interrupt line. A small number of global event sources (a MIDI receive request, a MIDI transmit-empty request and an interval-timer tick by default) each latch a sticky pending bit. Software sees those bits in a pending word and acknowledges them by writing ones back. A separate enable word decides which pending bits may raise the interrupt line. The same word holds a force bit that drives the line high regardless of pending state.

Beside the global sources, the block keeps one loop-interrupt pending flag and one enable flag per playback channel (64 by default). These are stored as 32-bit words. The enabled channel flags are reduced to a summary bit and the index of the highest enabled pending channel. Both appear in the low bits of the global pending word. Writing that word back with the summary bit set acknowledges exactly one channel. Software can therefore service channels one at a time: read the index, handle the channel, write the value back.

All state is reached through a simple word-addressed register port with a write strobe. Reads return combinationally in the same cycle.

Top module: `irq_aggregator`

## Requirements
- R1: After a synchronous active-low reset, every readable word reads 0 and `irq_o` is low.
- R2: A one on `src_evt_i[k]` in a cycle sets global pending bit 7+k of word 0. Rx is k=0 (bit 7), transmit-empty is k=1 (bit 8) and timer is k=2 (bit 9). The bit stays set until software clears it.
- R3: A write to word 0 clears every global pending bit (bits 7 and up) written as 1. Bits written as 0 keep their value.
- R4: When an event and a software clear hit the same global pending bit in the same cycle, the bit ends up set.
- R5: `irq_o` is high when any global pending bit k is set and its enable bit k (bit 0 to 2 of word 1) is set. A pending bit whose enable is 0 does not raise `irq_o`.
- R6: A one on `loop_evt_i[c]` sets channel pending bit c. Channels 0-31 sit in word 2 at bit c; channels 32-63 sit in word 3 at bit c-32. The bit stays set until cleared.
- R7: Bit 6 of word 0 reads 1 exactly when some channel has both pending and enable set. Bits 5:0 then give the highest such channel number. Without such a channel, bits 6:0 read 0 and the channel flags do not raise `irq_o`.
- R8: A write to word 0 with bit 6 set clears only the channel pending bit whose number is in bits 5:0 of the written data. With bit 6 clear, no channel pending bit changes.
- R9: A write to word 2 or word 3 clears every channel pending bit written as 1 in that word.
- R10: Words 4 (channels 0-31) and 5 (channels 32-63) hold the channel enables. They read back what was written.
- R11: Bit 31 of word 1 is the force bit. While it is set, `irq_o` is high whatever the pending state, and it reads back as written.
- R12: `rdata_o` reflects `addr_i` in the same cycle, and unmapped words (6 and 7) read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_evt_i | input | 3 | Global event requests, one per source |
| loop_evt_i | input | 64 | Per-channel loop-event requests |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data, same cycle |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions take event inputs as single-cycle requests sampled at the clock edge. They also assume that no write arrives on the same edge as the event they check, except where set-over-clear is the property itself. The channel summary property assumes the channel count is a power of two, so every 6-bit index names a real channel. The directed stimulus changes inputs only at the falling edge and pulses each event for exactly one cycle. It writes the pending word only with channel numbers below 64.

// File: rtl/irq_agg_pkg.sv
// Package: shared word type and register word map for the interrupt aggregator.
// Assumes a 32-bit register data path; the map is word-addressed.
package irq_agg_pkg;

    localparam int WORD_W = 32;

    typedef logic [WORD_W-1:0] word_t;

    // Fixed word indices; channel words follow from the channel count.
    localparam int REG_PEND    = 0;
    localparam int REG_ENABLE  = 1;
    localparam int REG_CH_BASE = 2;

endpackage

// File: rtl/irq_global_pend.sv
// Module: sticky pending bits for the global event sources.
// Each bit sets on its event and clears on a one in clr_i; a set in the
// same cycle as a clear wins. Assumes clr_i is already decoded by the caller.
module irq_global_pend #(
    parameter int NUM_SRC = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic [NUM_SRC-1:0] clr_i,
    output logic [NUM_SRC-1:0] pend_o
);

    logic [NUM_SRC-1:0] pend_q;

    // Update the pending bits: clear first, then let events override.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q & ~clr_i) | evt_i;
        end
    end

    assign pend_o = pend_q;

endmodule

// File: rtl/irq_chan_bank.sv
// Module: per-channel loop pending and enable flags, stored as data words.
// Pending bits set on set_i, clear on clr_i (set wins). Enable words load
// from wr_data_i when their strobe in en_wr_i is high.
// Assumes NUM_CHAN is a multiple of the word width.
module irq_chan_bank
    import irq_agg_pkg::*;
#(
    parameter int NUM_CHAN = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_CHAN-1:0] set_i,
    input  logic [NUM_CHAN-1:0] clr_i,
    input  logic [NUM_CHAN/WORD_W-1:0] en_wr_i,
    input  word_t               wr_data_i,
    output logic [NUM_CHAN-1:0] pend_o,
    output logic [NUM_CHAN-1:0] en_o
);

    localparam int NUM_WORDS = NUM_CHAN / WORD_W;

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        word_t pend_q;
        word_t en_q;

        // Hold the pending flags of this word of channels.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_q <= '0;
            end else begin
                pend_q <= (pend_q & ~clr_i[w*WORD_W +: WORD_W])
                        | set_i[w*WORD_W +: WORD_W];
            end
        end

        // Hold the enable flags of this word of channels.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_q <= '0;
            end else if (en_wr_i[w]) begin
                en_q <= wr_data_i;
            end
        end

        assign pend_o[w*WORD_W +: WORD_W] = pend_q;
        assign en_o[w*WORD_W +: WORD_W]   = en_q;
    end

endmodule

// File: rtl/irq_prio_enc.sv
// Module: highest-index priority encoder.
// any_o is high when any input bit is set; idx_o is the index of the
// highest set bit, or zero when none is set. Purely combinational.
module irq_prio_enc #(
    parameter int N     = 64,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     vec_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);

    // Scan upward so the last set bit found is the highest one.
    always_comb begin
        idx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (vec_i[i]) begin
                idx_o = IDX_W'(i);
            end
        end
    end

    assign any_o = |vec_i;

endmodule

// File: rtl/irq_aggregator.sv
// Module: top of the interrupt aggregator.
// Decodes the register port, holds the global enable word and force bit,
// and combines global and channel interrupt state into irq_o.
// Assumes the word-addressed map of irq_agg_pkg, single-cycle event pulses,
// and NUM_SRC small enough that the source bits fit below the force bit.
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int NUM_SRC  = 3,
    parameter int NUM_CHAN = 64,
    parameter int ADDR_W   = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SRC-1:0]  src_evt_i,
    input  logic [NUM_CHAN-1:0] loop_evt_i,
    input  logic                we_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [WORD_W-1:0]   wdata_i,
    output logic [WORD_W-1:0]   rdata_o,
    output logic                irq_o
);

    localparam int IDX_W      = $clog2(NUM_CHAN);
    localparam int NUM_WORDS  = NUM_CHAN / WORD_W;
    localparam int SUM_POS    = IDX_W;
    localparam int SRC_LSB    = IDX_W + 1;
    localparam int FORCE_POS  = WORD_W - 1;
    localparam int CH_PEND_LO = REG_CH_BASE;
    localparam int CH_EN_LO   = REG_CH_BASE + NUM_WORDS;

    logic                 wr_pend;
    logic                 wr_enable;
    logic [NUM_SRC-1:0]   gclr;
    logic [NUM_SRC-1:0]   gpend_q;
    logic [NUM_SRC-1:0]   gen_q;
    logic                 force_q;
    logic [NUM_CHAN-1:0]  chan_clr;
    logic [NUM_WORDS-1:0] chan_en_wr;
    logic [NUM_CHAN-1:0]  chan_pend;
    logic [NUM_CHAN-1:0]  chan_en;
    logic [NUM_CHAN-1:0]  chan_live;
    logic                 sum_flag;
    logic [IDX_W-1:0]     sum_idx;
    word_t                pend_word;

    assign wr_pend   = we_i && (addr_i == ADDR_W'(REG_PEND));
    assign wr_enable = we_i && (addr_i == ADDR_W'(REG_ENABLE));
    assign gclr      = wr_pend ? wdata_i[SRC_LSB +: NUM_SRC] : '0;

    irq_global_pend #(
        .NUM_SRC (NUM_SRC)
    ) u_gpend (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (src_evt_i),
        .clr_i  (gclr),
        .pend_o (gpend_q)
    );

    // Hold the global enable bits and the force bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gen_q   <= '0;
            force_q <= 1'b0;
        end else if (wr_enable) begin
            gen_q   <= wdata_i[NUM_SRC-1:0];
            force_q <= wdata_i[FORCE_POS];
        end
    end

    // Per-channel clear: one channel from the pending word, or W1C per word.
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_clr
        logic wr_word;
        assign wr_word       = we_i && (addr_i == ADDR_W'(CH_PEND_LO + w));
        assign chan_en_wr[w] = we_i && (addr_i == ADDR_W'(CH_EN_LO + w));
        for (genvar b = 0; b < WORD_W; b++) begin : g_bit
            localparam int CH = w * WORD_W + b;
            assign chan_clr[CH] = (wr_word && wdata_i[b])
                || (wr_pend && wdata_i[SUM_POS]
                    && (wdata_i[IDX_W-1:0] == IDX_W'(CH)));
        end
    end

    irq_chan_bank #(
        .NUM_CHAN (NUM_CHAN)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (loop_evt_i),
        .clr_i     (chan_clr),
        .en_wr_i   (chan_en_wr),
        .wr_data_i (wdata_i),
        .pend_o    (chan_pend),
        .en_o      (chan_en)
    );

    assign chan_live = chan_pend & chan_en;

    irq_prio_enc #(
        .N     (NUM_CHAN),
        .IDX_W (IDX_W)
    ) u_enc (
        .vec_i (chan_live),
        .any_o (sum_flag),
        .idx_o (sum_idx)
    );

    // Assemble the global pending word from sources and channel summary.
    always_comb begin
        pend_word                       = '0;
        pend_word[SRC_LSB +: NUM_SRC]   = gpend_q;
        pend_word[SUM_POS]              = sum_flag;
        pend_word[IDX_W-1:0]            = sum_idx;
    end

    // Select the read word for the current address.
    always_comb begin
        rdata_o = '0;
        if (addr_i == ADDR_W'(REG_PEND)) begin
            rdata_o = pend_word;
        end else if (addr_i == ADDR_W'(REG_ENABLE)) begin
            rdata_o[NUM_SRC-1:0] = gen_q;
            rdata_o[FORCE_POS]   = force_q;
        end else begin
            for (int w = 0; w < NUM_WORDS; w++) begin
                if (addr_i == ADDR_W'(CH_PEND_LO + w)) begin
                    rdata_o = chan_pend[w*WORD_W +: WORD_W];
                end
                if (addr_i == ADDR_W'(CH_EN_LO + w)) begin
                    rdata_o = chan_en[w*WORD_W +: WORD_W];
                end
            end
        end
    end

    assign irq_o = force_q || sum_flag || (|(gpend_q & gen_q));

endmodule

// File: rtl/irq_aggregator_chk.sv
// Module: assertion checker for irq_aggregator, attached by bind below.
// Assumes event inputs are one-cycle requests sampled at the clock edge.
module irq_aggregator_chk #(
    parameter int NUM_SRC  = 3,
    parameter int NUM_CHAN = 64,
    parameter int ADDR_W   = 3,
    parameter int WORD_W   = 32,
    parameter int IDX_W    = $clog2(NUM_CHAN)
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_SRC-1:0]  src_evt_i,
    input logic [NUM_CHAN-1:0] loop_evt_i,
    input logic                we_i,
    input logic [ADDR_W-1:0]   addr_i,
    input logic [WORD_W-1:0]   wdata_i,
    input logic                irq_o,
    input logic [NUM_SRC-1:0]  gpend_q,
    input logic                force_q,
    input logic [NUM_CHAN-1:0] chan_pend,
    input logic [NUM_CHAN-1:0] chan_en,
    input logic                sum_flag,
    input logic [IDX_W-1:0]    sum_idx
);

    localparam int SRC_LSB = IDX_W + 1;

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (gpend_q == '0 && chan_pend == '0 && chan_en == '0 && !force_q));

    p_event_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|src_evt_i) |=> ((gpend_q & $past(src_evt_i)) == $past(src_evt_i)));

    p_w1c_global_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i == '0)
        |=> ((gpend_q & $past(wdata_i[SRC_LSB +: NUM_SRC]) & ~$past(src_evt_i)) == '0));

    p_loop_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|loop_evt_i) |=> ((chan_pend & $past(loop_evt_i)) == $past(loop_evt_i)));

    p_highest_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sum_flag |-> (((chan_pend & chan_en) >> sum_idx) == NUM_CHAN'(1)));

    p_no_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !sum_flag |-> ((chan_pend & chan_en) == '0));

    p_force_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
        force_q |-> irq_o);

endmodule

bind irq_aggregator irq_aggregator_chk #(
    .NUM_SRC  (NUM_SRC),
    .NUM_CHAN (NUM_CHAN),
    .ADDR_W   (ADDR_W),
    .WORD_W   (irq_agg_pkg::WORD_W),
    .IDX_W    ($clog2(NUM_CHAN))
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_evt_i  (src_evt_i),
    .loop_evt_i (loop_evt_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .irq_o      (irq_o),
    .gpend_q    (gpend_q),
    .force_q    (force_q),
    .chan_pend  (chan_pend),
    .chan_en    (chan_en),
    .sum_flag   (sum_flag),
    .sum_idx    (sum_idx)
);

// File: tb/irq_aggregator_bench.sv
// Directed bench for irq_aggregator: one task per scenario, each self-checking.
module irq_aggregator_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  src_evt_i = '0;
    logic [63:0] loop_evt_i = '0;
    logic        we_i = 1'b0;
    logic [2:0]  addr_i = '0;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    irq_aggregator u_irq_aggregator (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_evt_i  (src_evt_i),
        .loop_evt_i (loop_evt_i),
        .we_i       (we_i),
        .addr_i     (addr_i),
        .wdata_i    (wdata_i),
        .rdata_o    (rdata_o),
        .irq_o      (irq_o)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        we_i = 1'b1; addr_i = a; wdata_i = d;
        @(negedge clk);
        we_i = 1'b0; wdata_i = '0;
    endtask

    task automatic rd_check(input string req, input logic [2:0] a, input logic [31:0] exp);
        @(negedge clk);
        addr_i = a;
        #1;
        check(req, rdata_o, exp);
    endtask

    task automatic irq_check(input string req, input logic exp);
        @(negedge clk);
        #1;
        check(req, {31'b0, irq_o}, {31'b0, exp});
    endtask

    task automatic pulse_src(input logic [2:0] v);
        @(negedge clk);
        src_evt_i = v;
        @(negedge clk);
        src_evt_i = '0;
    endtask

    task automatic pulse_loop(input logic [63:0] v);
        @(negedge clk);
        loop_evt_i = v;
        @(negedge clk);
        loop_evt_i = '0;
    endtask

    task automatic t_reset;
        for (int a = 0; a < 6; a++) rd_check("R1 reset word", 3'(a), 32'h0);
        irq_check("R1 reset irq", 1'b0);
    endtask

    task automatic t_global;
        pulse_src(3'b011);
        rd_check("R2 rx+tx latched", 3'd0, 32'h0000_0180);
        irq_check("R5 disabled pending no irq", 1'b0);
        wr(3'd0, 32'h0000_0100);
        rd_check("R3 clear tx only", 3'd0, 32'h0000_0080);
        wr(3'd0, 32'h0000_0000);
        rd_check("R3 zero write keeps", 3'd0, 32'h0000_0080);
        wr(3'd1, 32'h0000_0001);
        irq_check("R5 enabled rx raises irq", 1'b1);
        rd_check("R5 enable readback", 3'd1, 32'h0000_0001);
        wr(3'd1, 32'h0000_0002);
        irq_check("R5 other enable no irq", 1'b0);
        wr(3'd0, 32'h0000_0080);
        rd_check("R3 rx cleared", 3'd0, 32'h0);
        wr(3'd1, 32'h0);
    endtask

    task automatic t_set_wins;
        @(negedge clk);
        src_evt_i = 3'b100; we_i = 1'b1; addr_i = 3'd0; wdata_i = 32'h0000_0200;
        @(negedge clk);
        src_evt_i = '0; we_i = 1'b0; wdata_i = '0;
        rd_check("R4 set beats clear", 3'd0, 32'h0000_0200);
        wr(3'd0, 32'h0000_0200);
        rd_check("R3 timer cleared", 3'd0, 32'h0);
    endtask

    task automatic t_force;
        wr(3'd1, 32'h8000_0000);
        irq_check("R11 force irq", 1'b1);
        rd_check("R11 force readback", 3'd1, 32'h8000_0000);
        wr(3'd1, 32'h0);
        irq_check("R11 force off", 1'b0);
    endtask

    task automatic t_channels;
        logic [63:0] v;
        v = '0; v[3] = 1'b1; v[40] = 1'b1; v[63] = 1'b1;
        pulse_loop(v);
        rd_check("R6 low word", 3'd2, 32'h0000_0008);
        rd_check("R6 high word", 3'd3, 32'h8000_0100);
        rd_check("R7 no enabled summary", 3'd0, 32'h0);
        irq_check("R7 disabled channels no irq", 1'b0);
        wr(3'd4, 32'hFFFF_FFFF);
        wr(3'd5, 32'hFFFF_FFFF);
        rd_check("R10 enable high readback", 3'd5, 32'hFFFF_FFFF);
        rd_check("R7 highest is 63", 3'd0, 32'h0000_007F);
        irq_check("R7 summary irq", 1'b1);
        wr(3'd0, 32'h0000_0028);
        rd_check("R8 no summary bit no clear", 3'd3, 32'h8000_0100);
        wr(3'd0, 32'h0000_007F);
        rd_check("R8 ch63 cleared", 3'd3, 32'h0000_0100);
        rd_check("R7 highest now 40", 3'd0, 32'h0000_0068);
        wr(3'd0, 32'h0000_0043);
        rd_check("R8 ch3 cleared", 3'd2, 32'h0);
        rd_check("R8 ch40 kept", 3'd3, 32'h0000_0100);
        wr(3'd5, 32'h0);
        rd_check("R10 enable high cleared", 3'd5, 32'h0);
        rd_check("R7 masked summary", 3'd0, 32'h0);
        irq_check("R7 masked no irq", 1'b0);
        wr(3'd3, 32'h0000_0100);
        rd_check("R9 word clear", 3'd3, 32'h0);
        wr(3'd4, 32'h0);
    endtask

    task automatic t_unmapped;
        rd_check("R12 word 6 zero", 3'd6, 32'h0);
        rd_check("R12 word 7 zero", 3'd7, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_global();
        t_set_wins();
        t_force();
        t_channels();
        t_unmapped();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog got=hung exp=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule